// File: doc/BRIEF.md
# High-Speed UART Register and Interrupt Front End

This block sits between a simple 32-bit processor bus and the serial bit engine of a high-speed UART. It holds a transmit FIFO and a receive FIFO, each 64 entries deep by default, and presents five word registers: data, FIFO occupancy, interrupt status, control and baud divisor. Software writes bytes into the data register. The bit engine drains them through a pop port. Bytes that the engine receives are pushed in together with framing-error and break flags. Software reads each one back as a single word that also reports whether the receive queue was empty.

One interrupt line is built from two kinds of source. Some are latched events that stay set until software writes a one to them: transmit request, framing error, break and receive overrun. The others follow the state of the receive queue: the fill trigger and the inactivity timeout. Each source is masked by one of three group enables in the control register. The engine signals each idle character time with a pulse, and the block counts these pulses to detect receive inactivity.

Top module: `uart_hs_regs`

## Requirements
- R1: Registers are at byte offsets 0x00 data, 0x04 level, 0x08 status, 0x0C control and 0x10 divisor. After reset all of them read zero, except a data read, which returns 0x100. A data read with an empty receive queue returns bit 8 set with bits 7:0 zero, and it leaves the queue occupancy unchanged.
- R2: A bus write to offset 0x00 appends bits 7:0 to the transmit queue. `tx_valid` is high while that queue holds data, `tx_byte` shows the oldest entry, and a `tx_pop` pulse removes that entry.
- R3: A data read removes the oldest receive entry and returns its byte in bits 7:0, its framing-error flag in bit 9 and its break flag in bit 10, with bit 8 clear. Entries come back in arrival order.
- R4: The level register holds the transmit occupancy in bits 15:8 and the receive occupancy in bits 7:0.
- R5: Status bit 0 (transmit request) sets in the cycle after transmit occupancy drops from above to at or below the threshold chosen by control bits 1:0 (0 gives empty, 1 gives 4, 2 gives 8, 3 gives 16). It then stays set until cleared.
- R6: Writing a one to status bit 0, 3, 4 or 5 clears that bit, and writing a zero leaves it unchanged. Writing a one to status bit 6 sets bit 0. Bit 6 always reads zero.
- R7: Status bit 1 is high while receive occupancy is at least the level chosen by control bits 4:2 (0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 32, 5 and above give 48).
- R8: Status bit 2 is high when control bits 17:16 are non-zero and the receive queue holds data, and 4, 8 or 16 `rx_idle_tick` pulses (codes 1, 2 or 3) have come since the last receive push or data read. Code 0 disables it.
- R9: A receive push that carries the framing-error flag sets status bit 3. One that carries the break flag sets status bit 4.
- R10: A receive push while the receive queue is full is discarded, the stored entries are kept, and status bit 5 is set.
- R11: `irq` is the OR of three terms: status bit 0 AND control bit 5, status bits 1 or 2 AND control bit 6, and status bits 3, 4 or 5 AND control bit 7.
- R12: Control bit 8 drives `tx_break`. Divisor bits 7:0 drive `rate_div`. The control register reads back bits 1:0, 4:2, 5, 6, 7, 8 and 17:16 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Byte had a framing error |
| rx_break | input | 1 | Byte is a break condition |
| rx_idle_tick | input | 1 | One character time of line inactivity elapsed |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_break | output | 1 | Force break on the transmit line |
| rate_div | output | 8 | Baud divisor to the engine |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these rules: neither queue exceeds its depth, a push to a full receive queue leaves the overrun latch set, and a read of an empty queue keeps the occupancy at zero. They also check that write-one-to-clear removes a framing latch, that a timeout never shows while the queue is empty, and that a receive read or push clears the timeout. Other behaviour can only be shown by the directed scenarios. These cover the data ordering and flag packing across bus reads, the exact occupancy at which the transmit request fires, each trigger and timeout code, and whether a full queue keeps its oldest byte. They also cover the group-enable masking of `irq` and the set-through-bit-6 path.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;

    localparam int OFS_DATA  = 'h00;
    localparam int OFS_LEVEL = 'h04;
    localparam int OFS_ISR   = 'h08;
    localparam int OFS_CTRL  = 'h0C;
    localparam int OFS_RATE  = 'h10;

    // status bit positions
    localparam int ST_TXREQ = 0;
    localparam int ST_TRIG  = 1;
    localparam int ST_TMO   = 2;
    localparam int ST_FE    = 3;
    localparam int ST_BRK   = 4;
    localparam int ST_OE    = 5;
    localparam int ST_TXSET = 6;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic [7:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic [1:0] tmo;
        logic       brk;
        logic       err_ie;
        logic       rx_ie;
        logic       tx_ie;
        logic [2:0] rx_lvl;
        logic [1:0] tx_lvl;
    } ctrl_t;

    function automatic logic [7:0] rx_trig_bytes(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd1;
            3'd1:    return 8'd4;
            3'd2:    return 8'd8;
            3'd3:    return 8'd16;
            3'd4:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    function automatic logic [7:0] tx_trig_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd0;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd16;
        endcase
    endfunction

    function automatic logic [4:0] tmo_chars(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd0;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.tx_lvl = w[1:0];
        c.rx_lvl = w[4:2];
        c.tx_ie  = w[5];
        c.rx_ie  = w[6];
        c.err_ie = w[7];
        c.brk    = w[8];
        c.tmo    = w[17:16];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        return {14'd0, c.tmo, 7'd0, c.brk, c.err_ie, c.rx_ie, c.tx_ie, c.rx_lvl, c.tx_lvl};
    endfunction

endpackage

// File: rtl/uart_hs_fifo.sv
module uart_hs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10: occupancy never exceeds the depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R2: a lone accepted push raises occupancy by exactly one
    a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
        (do_push && !do_pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/uart_hs_rx_timeout.sv
module uart_hs_rx_timeout (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       idle_tick,
    input  logic       activity,
    input  logic       holding,
    output logic       timeout
);
    import uart_hs_pkg::*;

    logic [4:0] cnt;
    logic [4:0] limit;

    assign limit = tmo_chars(mode);

    always_ff @(posedge clk) begin
        if (rst || activity || !holding)
            cnt <= '0;
        else if (idle_tick && cnt < limit)
            cnt <= cnt + 1'b1;
    end

    assign timeout = (mode != 2'd0) && holding && (cnt >= limit);

    // R8: any queue activity removes the timeout on the next cycle
    a_r8_activity_clears: assert property (@(posedge clk) disable iff (rst)
        (activity && mode != 2'd0 && $stable(mode)) |=> !timeout);

endmodule

// File: rtl/uart_hs_regs.sv
module uart_hs_regs
    import uart_hs_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic              rx_idle_tick,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    output logic              tx_break,
    output logic [7:0]        rate_div,
    output logic              irq
);
    localparam int CW   = $clog2(FIFO_DEPTH + 1);
    localparam int RX_W = $bits(rx_entry_t);

    logic sel_data, sel_level, sel_isr, sel_ctrl, sel_rate;
    assign sel_data  = (bus_addr == ADDR_W'(OFS_DATA));
    assign sel_level = (bus_addr == ADDR_W'(OFS_LEVEL));
    assign sel_isr   = (bus_addr == ADDR_W'(OFS_ISR));
    assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_rate  = (bus_addr == ADDR_W'(OFS_RATE));

    ctrl_t      ctrl_q;
    logic [7:0] rate_q;
    logic       txreq_q, fe_q, brk_q, oe_q, tx_above_q;

    rx_entry_t        rx_in, rx_head;
    logic [CW-1:0]    rx_cnt, tx_cnt;
    logic             rx_full, rx_empty, tx_full, tx_empty;
    logic             rx_pop, tx_push;
    logic [7:0]       rx_lvl8, tx_lvl8;
    logic             rx_trig, rx_tmo, tx_above, tx_fall;
    logic [6:0]       isr;
    logic [31:0]      w1c;

    assign rx_pop  = bus_rd && sel_data;
    assign tx_push = bus_wr && sel_data;
    assign rx_in   = '{brk: rx_break, ferr: rx_frame_err, data: rx_byte};

    uart_hs_fifo #(.W(RX_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_in), .pop(rx_pop),
        .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    uart_hs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk(clk), .rst(rst), .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop),
        .dout(tx_byte), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    uart_hs_rx_timeout i_rx_tmo (
        .clk(clk), .rst(rst), .mode(ctrl_q.tmo), .idle_tick(rx_idle_tick),
        .activity(rx_push || rx_pop), .holding(!rx_empty), .timeout(rx_tmo));

    assign rx_lvl8  = 8'(rx_cnt);
    assign tx_lvl8  = 8'(tx_cnt);
    assign rx_trig  = rx_lvl8 >= rx_trig_bytes(ctrl_q.rx_lvl);
    assign tx_above = tx_lvl8 > tx_trig_bytes(ctrl_q.tx_lvl);
    assign tx_fall  = tx_above_q && !tx_above;
    assign w1c      = (bus_wr && sel_isr) ? bus_wdata : 32'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            rate_q     <= '0;
            txreq_q    <= 1'b0;
            fe_q       <= 1'b0;
            brk_q      <= 1'b0;
            oe_q       <= 1'b0;
            tx_above_q <= 1'b0;
        end else begin
            tx_above_q <= tx_above;
            if (bus_wr && sel_ctrl) ctrl_q <= ctrl_from_word(bus_wdata);
            if (bus_wr && sel_rate) rate_q <= bus_wdata[7:0];

            if (tx_fall || w1c[ST_TXSET])            txreq_q <= 1'b1;
            else if (w1c[ST_TXREQ])                  txreq_q <= 1'b0;
            if (rx_push && rx_frame_err)             fe_q <= 1'b1;
            else if (w1c[ST_FE])                     fe_q <= 1'b0;
            if (rx_push && rx_break)                 brk_q <= 1'b1;
            else if (w1c[ST_BRK])                    brk_q <= 1'b0;
            if (rx_push && rx_full)                  oe_q <= 1'b1;
            else if (w1c[ST_OE])                     oe_q <= 1'b0;
        end
    end

    always_comb begin
        isr           = '0;
        isr[ST_TXREQ] = txreq_q;
        isr[ST_TRIG]  = rx_trig;
        isr[ST_TMO]   = rx_tmo;
        isr[ST_FE]    = fe_q;
        isr[ST_BRK]   = brk_q;
        isr[ST_OE]    = oe_q;
    end

    assign irq = (isr[ST_TXREQ] && ctrl_q.tx_ie)
               || ((isr[ST_TRIG] || isr[ST_TMO]) && ctrl_q.rx_ie)
               || ((isr[ST_FE] || isr[ST_BRK] || isr[ST_OE]) && ctrl_q.err_ie);

    always_comb begin
        bus_rdata = '0;
        if (sel_data)
            bus_rdata = rx_empty ? 32'h100
                                 : {21'd0, rx_head.brk, rx_head.ferr, 1'b0, rx_head.data};
        else if (sel_level) bus_rdata = {16'd0, tx_lvl8, rx_lvl8};
        else if (sel_isr)   bus_rdata = {25'd0, isr};
        else if (sel_ctrl)  bus_rdata = ctrl_to_word(ctrl_q);
        else if (sel_rate)  bus_rdata = {24'd0, rate_q};
    end

    assign tx_valid = !tx_empty;
    assign tx_break = ctrl_q.brk;
    assign rate_div = rate_q;

    // R10: a push into a full receive queue leaves the overrun latch set
    a_r10_overrun_latched: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full) |=> oe_q);
    // R1: reading an empty receive queue keeps it empty
    a_r1_empty_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty && !rx_push) |=> (rx_cnt == '0));
    // R6: write-one-to-clear removes the framing latch
    a_r6_w1c_fe: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_isr && bus_wdata[ST_FE] && !(rx_push && rx_frame_err)) |=> !fe_q);
    // R8: a timeout never shows with nothing queued
    a_r8_tmo_needs_data: assert property (@(posedge clk) disable iff (rst)
        rx_tmo |-> (rx_lvl8 != 8'd0));
    // R11: no interrupt while every group is masked
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.tx_ie && !ctrl_q.rx_ie && !ctrl_q.err_ie) |-> !irq);

endmodule

// File: tb/test_uart_hs_regs.sv
module test_uart_hs_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_push = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0, rx_idle_tick = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte, rate_div;
    logic        tx_valid, tx_break, irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    uart_hs_regs i_uart_hs_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break), .rx_idle_tick(rx_idle_tick),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_break(tx_break),
        .rate_div(rate_div), .irq(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b, input logic fe, input logic br);
        @(negedge clk); rx_push = 1'b1; rx_byte = b; rx_frame_err = fe; rx_break = br;
        @(negedge clk); rx_push = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic idle_tick();
        @(negedge clk); rx_idle_tick = 1'b1;
        @(negedge clk); rx_idle_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h04, d); check("R1 level after reset", d, 32'h0);
        rd(5'h08, d); check("R1 status after reset", d, 32'h0);
        rd(5'h0C, d); check("R1 control after reset", d, 32'h0);
        rd(5'h10, d); check("R1 divisor after reset", d, 32'h0);
        check("R11 irq after reset", {31'd0, irq}, 32'h0);
        rd(5'h00, d); check("R1 empty data read", d, 32'h100);
        rd(5'h04, d); check("R1 empty read keeps level", d, 32'h0);
    endtask

    task automatic t_tx_path();
        logic [31:0] d;
        wr(5'h00, 32'hAB); wr(5'h00, 32'h1CD); wr(5'h00, 32'hEF);
        rd(5'h04, d); check("R4 tx level 3", d, 32'h0300);
        check("R2 tx_valid", {31'd0, tx_valid}, 32'h1);
        check("R2 head byte 0", {24'd0, tx_byte}, 32'hAB); pop_tx();
        check("R2 head byte 1", {24'd0, tx_byte}, 32'hCD); pop_tx();
        check("R2 head byte 2", {24'd0, tx_byte}, 32'hEF); pop_tx();
        check("R2 tx drained", {31'd0, tx_valid}, 32'h0);
        rd(5'h08, d); check("R5 empty threshold sets request", d, 32'h01);
        wr(5'h08, 32'h01);
        rd(5'h08, d); check("R6 request cleared", d, 32'h0);
    endtask

    task automatic t_tx_request();
        logic [31:0] d;
        wr(5'h0C, 32'h21);   // threshold code 1 (4 bytes), transmit enable
        for (int i = 0; i < 6; i++) wr(5'h00, 32'(8'h10 + i));
        pop_tx();
        rd(5'h08, d); check("R5 occupancy 5 no request", d, 32'h0);
        check("R11 irq low before request", {31'd0, irq}, 32'h0);
        pop_tx();
        rd(5'h08, d); check("R5 occupancy 4 request", d, 32'h01);
        check("R11 tx irq", {31'd0, irq}, 32'h1);
        wr(5'h08, 32'h0);
        rd(5'h08, d); check("R6 write zero keeps request", d, 32'h01);
        wr(5'h08, 32'h01);
        rd(5'h08, d); check("R6 request cleared at level", d, 32'h0);
        for (int i = 0; i < 4; i++) pop_tx();
        rd(5'h08, d); check("R5 no second request", d, 32'h0);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_rx_path();
        logic [31:0] d;
        push_rx(8'h41, 1'b0, 1'b0);
        push_rx(8'h42, 1'b1, 1'b0);
        push_rx(8'h43, 1'b0, 1'b1);
        rd(5'h04, d); check("R4 rx level 3", d, 32'h03);
        rd(5'h08, d); check("R9 fe and brk latched", d, 32'h1A);
        rd(5'h00, d); check("R3 word 0", d, 32'h041);
        rd(5'h00, d); check("R3 word ferr", d, 32'h242);
        rd(5'h00, d); check("R3 word break", d, 32'h443);
        rd(5'h08, d); check("R9 latches persist after drain", d, 32'h18);
        wr(5'h08, 32'h18);
        rd(5'h08, d); check("R6 fe brk cleared", d, 32'h0);
    endtask

    task automatic t_rx_trigger();
        logic [31:0] d;
        wr(5'h0C, 32'h44);   // rx trigger code 1 (4 bytes), receive enable
        for (int i = 0; i < 3; i++) push_rx(8'(i), 1'b0, 1'b0);
        rd(5'h08, d); check("R7 below trigger", d, 32'h0);
        check("R11 no rx irq", {31'd0, irq}, 32'h0);
        push_rx(8'h03, 1'b0, 1'b0);
        rd(5'h08, d); check("R7 at trigger", d, 32'h02);
        check("R11 rx irq", {31'd0, irq}, 32'h1);
        for (int i = 0; i < 4; i++) rd(5'h00, d);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        wr(5'h0C, 32'h94);   // rx trigger code 5, error enable
        for (int i = 0; i < 65; i++) push_rx(8'(8'h80 + i), 1'b0, 1'b0);
        rd(5'h04, d); check("R10 level capped", d, 32'h40);
        rd(5'h08, d); check("R10 overrun latched", d, 32'h22);
        check("R11 error irq", {31'd0, irq}, 32'h1);
        rd(5'h00, d); check("R10 oldest kept", d, 32'h80);
        for (int i = 0; i < 62; i++) rd(5'h00, d);
        rd(5'h00, d); check("R10 last stored byte", d, 32'hBF);
        wr(5'h08, 32'h20);
        rd(5'h08, d); check("R6 overrun cleared", d, 32'h0);
        check("R11 irq drops", {31'd0, irq}, 32'h0);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        wr(5'h0C, 32'h10014);   // timeout code 1, rx trigger code 5
        push_rx(8'h55, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) idle_tick();
        rd(5'h08, d); check("R8 three ticks no timeout", d, 32'h0);
        idle_tick();
        rd(5'h08, d); check("R8 four ticks timeout", d, 32'h04);
        rd(5'h00, d); check("R3 timeout byte", d, 32'h55);
        rd(5'h08, d); check("R8 cleared by read", d, 32'h0);
        wr(5'h0C, 32'h14);      // timeout disabled
        push_rx(8'h66, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) idle_tick();
        rd(5'h08, d); check("R8 disabled code", d, 32'h0);
        rd(5'h00, d);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        rd(5'h00, d); check("R1 empty read word", d, 32'h100);
        push_rx(8'h77, 1'b0, 1'b0);
        rd(5'h04, d); check("R1 level after empty read", d, 32'h01);
        rd(5'h00, d); check("R1 byte after empty read", d, 32'h77);
    endtask

    task automatic t_ctrl_rate();
        logic [31:0] d;
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, d); check("R12 control readback", d, 32'h301FF);
        check("R12 tx_break high", {31'd0, tx_break}, 32'h1);
        wr(5'h0C, 32'h0);
        check("R12 tx_break low", {31'd0, tx_break}, 32'h0);
        wr(5'h10, 32'h1A5);
        rd(5'h10, d); check("R12 divisor readback", d, 32'hA5);
        check("R12 rate_div", {24'd0, rate_div}, 32'hA5);
    endtask

    task automatic t_set_and_mask();
        logic [31:0] d;
        wr(5'h08, 32'h40);
        rd(5'h08, d); check("R6 bit 6 sets request", d, 32'h01);
        check("R11 request masked", {31'd0, irq}, 32'h0);
        wr(5'h0C, 32'h20);
        check("R11 request enabled", {31'd0, irq}, 32'h1);
        wr(5'h08, 32'h01);
        check("R11 irq after clear", {31'd0, irq}, 32'h0);
        push_rx(8'h01, 1'b1, 1'b0);
        rd(5'h00, d);
        check("R11 fe masked by group", {31'd0, irq}, 32'h0);
        wr(5'h0C, 32'h80);
        check("R11 fe with error enable", {31'd0, irq}, 32'h1);
        wr(5'h08, 32'h08);
        wr(5'h0C, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_path();
        t_tx_request();
        t_rx_path();
        t_rx_trigger();
        t_overrun();
        t_timeout();
        t_empty_read();
        t_ctrl_rate();
        t_set_and_mask();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule